// File: doc/BRIEF.md
# Integration Cycle Timing Controller

This block paces the conversion windows of a two-channel light-sensing front end. It opens an integration window only while the power field reads as fully on. In one of three preset modes it repeats fixed-length windows back to back. In manual mode, software opens and closes each window with a single control bit. The window is shown on `integrateActive`, which gates the external accumulators.

When a window closes normally, the block raises `convDone` for one clock. On that same clock edge it captures the two accumulator values into result registers, which then hold until the next normal close. Changing the select code or dropping power in the middle of a window discards that window with no done pulse, and the next window starts from zero. The gain bit is not used by the timing and is passed straight through to the analog side.

The three preset lengths are parameters counted in clock ticks. Their defaults (137, 1010 and 4020 ticks) keep the nominal 13.7 : 101 : 402 ms proportion, which is roughly 0.034 : 0.252 : 1.

Top module: `intg_timing_ctrl`

## Requirements
- R1: After reset, `integrateActive` and `convDone` are 0 and both result registers are 0.
- R2: Windows run only while `powerBits` equals 2'b11. In any other state, `integrateActive` is 0 one clock later and no `convDone` pulse occurs. Dropping power mid-window discards that window.
- R3: For `integSel` codes 2'b00, 2'b01 and 2'b10, each window lasts LEN_SHORT, LEN_MID and LEN_LONG clocks respectively. Windows repeat back to back, so `convDone` pulses exactly one window length apart. `integrateActive` rises one clock after power and the select code are both settled.
- R4: `convDone` is high for exactly one clock after the final tick of a window. On that same edge, `chan0Result` and `chan1Result` take the values of `chan0Acc` and `chan1Acc`.
- R5: If `integSel` changes while powered, the open window is discarded with no `convDone`. `integrateActive` is 0 for the following clock, and a fresh window then starts.
- R6: With `integSel` = 2'b11, `manualBit` at 1 opens a window on the next clock. When `manualBit` returns to 0, the window closes and gives one `convDone` pulse with result capture.
- R7: `manualBit` has no effect while `integSel` selects a preset code: window timing and `convDone` spacing stay unchanged.
- R8: `gainHigh` always equals `gainBit` (0 for 1x, 1 for 16x), with no clock delay.
- R9: The result registers hold their value in every clock in which `convDone` is 0.
- R10: Leaving manual mode while a manual window is open discards the window with no `convDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Synchronous reset, active low |
| powerBits | input | 2 | Power field; 2'b11 enables operation |
| integSel | input | 2 | Window select: three preset lengths or manual (2'b11) |
| manualBit | input | 1 | Manual start (1) / stop (0), used only in manual mode |
| gainBit | input | 1 | Gain select, passed through |
| chan0Acc | input | DATA_W | Channel-0 accumulator value |
| chan1Acc | input | DATA_W | Channel-1 accumulator value |
| integrateActive | output | 1 | High while an integration window is open |
| convDone | output | 1 | One-clock pulse at each completed window |
| chan0Result | output | DATA_W | Captured channel-0 result |
| chan1Result | output | DATA_W | Captured channel-1 result |
| gainHigh | output | 1 | Copy of `gainBit` |

## Verification
The hardest case to reach from the ports is a window that is discarded in its last few ticks. With long preset windows, a random change of select or power almost never lands that close to the end. The bench therefore shrinks the three lengths to 17, 126 and 500 ticks, keeping the same proportion. It then mixes directed aborts at chosen tick offsets with a long random run in which select, power and the manual bit change with small per-clock probabilities. A cycle-level model in the bench predicts every output, so each abort, manual close and ignored manual toggle is checked in the exact cycle it should take effect.

// File: rtl/intg_pkg.sv
package intg_pkg;

  localparam logic [1:0] POWER_ON = 2'b11;

  typedef enum logic [1:0] {
    SEL_SHORT  = 2'b00,
    SEL_MID    = 2'b01,
    SEL_LONG   = 2'b10,
    SEL_MANUAL = 2'b11
  } intgSel_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic capture;   // window closed normally: pulse done and latch results
  } intgStrobe_t;

endpackage

// File: rtl/intg_ctrl.sv
module intg_ctrl
  import intg_pkg::*;
#(
  parameter int unsigned LEN_SHORT = 137,
  parameter int unsigned LEN_MID   = 1010,
  parameter int unsigned LEN_LONG  = 4020
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  powerBits,
  input  logic [1:0]  integSel,
  input  logic        manualBit,
  output logic        windowOpen,
  output intgStrobe_t strobe
);

  localparam int unsigned LEN_MAX01 = (LEN_SHORT > LEN_MID) ? LEN_SHORT : LEN_MID;
  localparam int unsigned LEN_MAX   = (LEN_MAX01 > LEN_LONG) ? LEN_MAX01 : LEN_LONG;
  localparam int unsigned CNT_W     = (LEN_MAX > 2) ? $clog2(LEN_MAX) : 1;

  logic             powered;
  logic             selHeld;
  logic             manualMode;
  logic [1:0]       selQ;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] tickCntNxt;
  logic [CNT_W-1:0] lastTick;
  logic             windowOpenNxt;

  assign powered    = (powerBits == POWER_ON);
  assign selHeld    = (integSel == selQ);
  assign manualMode = (integSel == SEL_MANUAL);

  // last tick index of the selected preset window
  always_comb begin
    unique case (integSel)
      SEL_SHORT: lastTick = CNT_W'(LEN_SHORT - 1);
      SEL_MID:   lastTick = CNT_W'(LEN_MID - 1);
      SEL_LONG:  lastTick = CNT_W'(LEN_LONG - 1);
      default:   lastTick = '0;
    endcase
  end

  always_comb begin
    windowOpenNxt  = windowOpen;
    tickCntNxt     = tickCnt;
    strobe         = '0;
    if (!powered || !selHeld) begin
      // power off or select just changed: discard any open window
      windowOpenNxt = 1'b0;
      tickCntNxt    = '0;
    end else if (!manualMode) begin
      if (!windowOpen) begin
        windowOpenNxt = 1'b1;
        tickCntNxt    = '0;
      end else if (tickCnt == lastTick) begin
        strobe.capture = 1'b1;
        tickCntNxt     = '0;
      end else begin
        tickCntNxt = tickCnt + 1'b1;
      end
    end else begin
      tickCntNxt = '0;
      if (!windowOpen && manualBit) begin
        windowOpenNxt = 1'b1;
      end else if (windowOpen && !manualBit) begin
        windowOpenNxt  = 1'b0;
        strobe.capture = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      windowOpen <= 1'b0;
      tickCnt    <= '0;
      selQ       <= SEL_SHORT;
    end else begin
      windowOpen <= windowOpenNxt;
      tickCnt    <= tickCntNxt;
      selQ       <= integSel;
    end
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (powered && selHeld && windowOpen && !manualMode) |-> (tickCnt <= lastTick)); // R3

  AST_UNPOWERED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !powered |=> !windowOpen); // R2

  AST_SEL_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (powered && !selHeld) |=> !windowOpen); // R5

  AST_MANUAL_START: assert property (@(posedge clk) disable iff (!rstN)
    (powered && selHeld && manualMode && manualBit && !windowOpen) |=> windowOpen); // R6

endmodule

// File: rtl/intg_datapath.sv
module intg_datapath
  import intg_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  intgStrobe_t       strobe,
  input  logic [DATA_W-1:0] chan0Acc,
  input  logic [DATA_W-1:0] chan1Acc,
  input  logic              gainBit,
  output logic              convDone,
  output logic [DATA_W-1:0] chan0Result,
  output logic [DATA_W-1:0] chan1Result,
  output logic              gainHigh
);

  assign gainHigh = gainBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      convDone    <= 1'b0;
      chan0Result <= '0;
      chan1Result <= '0;
    end else begin
      convDone <= strobe.capture;
      if (strobe.capture) begin
        chan0Result <= chan0Acc;
        chan1Result <= chan1Acc;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone); // R4

endmodule

// File: rtl/intg_timing_ctrl.sv
module intg_timing_ctrl
  import intg_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned LEN_SHORT = 137,
  parameter int unsigned LEN_MID   = 1010,
  parameter int unsigned LEN_LONG  = 4020
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        powerBits,
  input  logic [1:0]        integSel,
  input  logic              manualBit,
  input  logic              gainBit,
  input  logic [DATA_W-1:0] chan0Acc,
  input  logic [DATA_W-1:0] chan1Acc,
  output logic              integrateActive,
  output logic              convDone,
  output logic [DATA_W-1:0] chan0Result,
  output logic [DATA_W-1:0] chan1Result,
  output logic              gainHigh
);

  intgStrobe_t strobe;

  intg_ctrl #(
    .LEN_SHORT (LEN_SHORT),
    .LEN_MID   (LEN_MID),
    .LEN_LONG  (LEN_LONG)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .powerBits  (powerBits),
    .integSel   (integSel),
    .manualBit  (manualBit),
    .windowOpen (integrateActive),
    .strobe     (strobe)
  );

  intg_datapath #(
    .DATA_W (DATA_W)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .chan0Acc    (chan0Acc),
    .chan1Acc    (chan1Acc),
    .gainBit     (gainBit),
    .convDone    (convDone),
    .chan0Result (chan0Result),
    .chan1Result (chan1Result),
    .gainHigh    (gainHigh)
  );

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !convDone |-> ($stable(chan0Result) && $stable(chan1Result))); // R9

  AST_DONE_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> $past(integrateActive)); // R4

endmodule

// File: tb/test_intg_timing_ctrl.sv
`timescale 1ns/1ps
module test_intg_timing_ctrl;

  localparam int unsigned DW = 16;
  localparam int unsigned L0 = 17;
  localparam int unsigned L1 = 126;
  localparam int unsigned L2 = 500;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    powerBits = 2'b00;
  logic [1:0]    integSel = 2'b00;
  logic          manualBit = 1'b0;
  logic          gainBit = 1'b0;
  logic [DW-1:0] chan0Acc = '0;
  logic [DW-1:0] chan1Acc = '0;
  logic          integrateActive;
  logic          convDone;
  logic [DW-1:0] chan0Result;
  logic [DW-1:0] chan1Result;
  logic          gainHigh;

  always #4 clk = ~clk;

  intg_timing_ctrl #(
    .DATA_W (DW), .LEN_SHORT (L0), .LEN_MID (L1), .LEN_LONG (L2)
  ) i_intg_timing_ctrl (
    .clk (clk), .rstN (rstN), .powerBits (powerBits), .integSel (integSel),
    .manualBit (manualBit), .gainBit (gainBit), .chan0Acc (chan0Acc),
    .chan1Acc (chan1Acc), .integrateActive (integrateActive),
    .convDone (convDone), .chan0Result (chan0Result),
    .chan1Result (chan1Result), .gainHigh (gainHigh)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int cycleNo = 0;

  // reference model state
  bit          mAct, mDone;
  int          mCnt;
  logic [1:0]  mSelQ;
  logic [DW-1:0] mR0, mR1;

  function automatic int winLen(logic [1:0] s);
    case (s)
      2'b00: return L0;
      2'b01: return L1;
      default: return L2;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mAct = 0; mDone = 0; mCnt = 0; mSelQ = 2'b00; mR0 = '0; mR1 = '0;
    end else begin
      mDone = 0;
      if (powerBits != 2'b11 || integSel != mSelQ) begin
        mAct = 0; mCnt = 0;
      end else if (integSel != 2'b11) begin
        if (!mAct) begin mAct = 1; mCnt = 0; end
        else if (mCnt == winLen(integSel) - 1) begin
          mDone = 1; mR0 = chan0Acc; mR1 = chan1Acc; mCnt = 0;
        end else mCnt++;
      end else begin
        if (!mAct && manualBit) mAct = 1;
        else if (mAct && !manualBit) begin
          mAct = 0; mDone = 1; mR0 = chan0Acc; mR1 = chan1Acc;
        end
      end
      mSelQ = integSel;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, cycleNo, act, exp);
    end
  endtask

  string curReq = "R3";
  bit    gapOn = 0;
  int    gapExp = 0;
  int    lastDone = -1;
  int    doneSeen = 0;

  // advance one clock; compare at the falling edge; new inputs follow
  task automatic cyc();
    @(negedge clk);
    cycleNo++;
    chk(integrateActive == mAct, curReq, "integrateActive", integrateActive, mAct);
    chk(convDone == mDone, (mDone ? "R4" : curReq), "convDone", convDone, mDone);
    chk(chan0Result == mR0 && chan1Result == mR1, (convDone ? "R4" : "R9"),
        "results", {chan0Result, chan1Result}, {mR0, mR1});
    chk(gainHigh == gainBit, "R8", "gainHigh", gainHigh, gainBit);
    if (convDone) begin
      doneSeen++;
      if (gapOn && lastDone >= 0)
        chk(cycleNo - lastDone == gapExp, curReq, "done spacing", cycleNo - lastDone, gapExp);
      lastDone = cycleNo;
    end
    chan0Acc = DW'($urandom);
    chan1Acc = DW'($urandom);
    gainBit  = 1'($urandom);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!integrateActive && !convDone && chan0Result == 0 && chan1Result == 0,
        "R1", "reset state", {integrateActive, convDone}, 0);
    rstN = 1'b1;

    // R2: partial power codes never open a window
    curReq = "R2"; powerBits = 2'b01; run(30);
    chk(doneSeen == 0, "R2", "done while unpowered", doneSeen, 0);
    powerBits = 2'b10; run(10);

    // R3: three preset lengths, spacing equals window length
    powerBits = 2'b11; curReq = "R3"; gapOn = 1;
    for (int s = 0; s < 3; s++) begin
      integSel = 2'(s); gapExp = winLen(2'(s)); lastDone = -1; doneSeen = 0;
      run(winLen(2'(s)) * 3 + 4);
      chk(doneSeen >= 3, "R3", "window count", doneSeen, 3);
    end

    // R7: manual bit toggling in a preset mode changes nothing
    curReq = "R7"; integSel = 2'b00; run(3); lastDone = -1; gapExp = L0;
    for (int i = 0; i < 80; i++) begin manualBit = 1'($urandom); cyc(); end
    manualBit = 0;

    // R5: select change late in a window discards it
    gapOn = 0; curReq = "R5";
    integSel = 2'b01; run(2 + L1 - 3);
    integSel = 2'b00; doneSeen = 0; cyc();
    chk(!integrateActive, "R5", "idle after select change", integrateActive, 0);
    run(3);
    chk(doneSeen == 0, "R5", "no done on abort", doneSeen, 0);

    // R2: power drop one tick before the window end
    curReq = "R2"; run(L0 + 30);
    while (!convDone) cyc();
    run(L0 - 2); powerBits = 2'b00; doneSeen = 0; cyc();
    chk(!integrateActive, "R2", "window closed on power drop", integrateActive, 0);
    run(L0 + 4);
    chk(doneSeen == 0, "R2", "no done after power drop", doneSeen, 0);
    powerBits = 2'b11;

    // R6: manual open and close
    curReq = "R6"; integSel = 2'b11; run(3);
    manualBit = 1; cyc();
    chk(integrateActive, "R6", "manual start", integrateActive, 1);
    run(40); manualBit = 0; doneSeen = 0; cyc();
    chk(convDone && !integrateActive, "R6", "manual stop done", {convDone, integrateActive}, 2'b10);
    run(5);
    chk(doneSeen == 1, "R6", "single done", doneSeen, 1);

    // R10: leave manual mode with window open
    curReq = "R10"; manualBit = 1; run(10);
    integSel = 2'b10; doneSeen = 0; run(4);
    chk(doneSeen == 0, "R10", "no done leaving manual", doneSeen, 0);
    manualBit = 0;

    // random mix
    curReq = "R3";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(199) == 0) integSel = 2'($urandom);
      if ($urandom_range(299) == 0) powerBits = ($urandom_range(3) == 0) ? 2'($urandom) : 2'b11;
      if ($urandom_range(39) == 0) manualBit = ~manualBit;
      curReq = (integSel == 2'b11) ? "R6" : "R3";
      cyc();
    end

    report();
  end

endmodule